// File: doc/BRIEF.md
# Bidirectional GPIO Port Controller

This block is the pin-facing I/O unit of a small 8-bit microcontroller. It has two bidirectional ports: an 8-bit wide port and a 2-bit narrow port. Each port has a data latch and a direction register, and software reaches both through a byte-wide register bus that reads combinationally and writes on the clock edge. A direction bit of one makes its pin an output driven from the latch. A direction bit of zero leaves the pin as an input. A read of a data register merges the two sources bit by bit: output bits return the latch and input bits return the synchronized pin level.

Configuration inputs let peripherals take over individual pins. The low six wide-port pins can carry PWM channels. The top two wide-port pins can carry serial-port outputs. The two narrow-port pins can join an open-drain serial bus, where a pin is either pulled low or released. While a peripheral owns a pin, the latch and direction bits stay intact, and software sees them again once the pin is released. Every pin input passes through a two-flop synchronizer, and the same synchronized values go out to the peripherals.

Top module: `gpio_port_unit`

## Requirements
- R1: While reset (synchronous, active low) is held, both direction registers clear to zero. After reset, every pin that no peripheral owns has its output enable low, and both direction registers read back as zero.
- R2: Reset does not change either data latch. A value written before reset is read back afterwards once the direction bits are set.
- R3: The register addresses are 0x02 (wide data), 0x06 (wide direction), 0x03 (narrow data) and 0x07 (narrow direction). A write takes effect on the rising edge where the write strobe is high. A write to any other address changes nothing.
- R4: On a pin that no peripheral owns, a direction bit of 1 sets the output enable and drives the latch bit onto the pin. A direction bit of 0 clears the output enable.
- R5: A write to a data register updates the latch whatever the direction bits hold.
- R6: A data register read returns, in each bit, the latch where the direction bit is 1 and the synchronized pin where it is 0. A direction register read returns the stored bits. On the narrow port, read bits 7 to 2 are 0.
- R7: A pin input change shows on the read data and on the synchronized outputs after exactly two rising edges.
- R8: When PWM select bit i (i = 0 to 5) is 1, wide pin i is driven with PWM value bit i and its output enable is high.
- R9: When serial select bit j is 1, wide pin 6+j is driven with serial value bit j and its output enable is high.
- R10: When bus select bit k is 1, narrow pin k is open drain: its drive value is 0 and its output enable is the inverse of bus value bit k.
- R11: While a peripheral owns a pin, register writes still update the latch and direction register. On release, the pin follows them again.
- R12: The read data is zero whenever the read strobe is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 8 | Register address |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data (combinational) |
| wide_pin_in | input | 8 | Wide-port pin levels |
| wide_pin_out | output | 8 | Wide-port drive values |
| wide_pin_oe | output | 8 | Wide-port output enables |
| wide_pin_sync | output | 8 | Synchronized wide-port pin levels for peripherals |
| narrow_pin_in | input | 2 | Narrow-port pin levels |
| narrow_pin_out | output | 2 | Narrow-port drive values |
| narrow_pin_oe | output | 2 | Narrow-port output enables |
| narrow_pin_sync | output | 2 | Synchronized narrow-port pin levels |
| pwm_sel | input | 6 | PWM ownership of wide pins 0 to 5 |
| pwm_val | input | 6 | PWM output values |
| ser_sel | input | 2 | Serial-port ownership of wide pins 6 and 7 |
| ser_val | input | 2 | Serial-port output values |
| sbus_sel | input | 2 | Open-drain bus ownership of narrow pins |
| sbus_val | input | 2 | Bus drive request (0 pulls low) |

## Verification
The bench targets the mixed read path. It sets some direction bits and leaves others clear, so a design that returned only the latch or only the pin would produce a wrong merged byte. It moves a pin while watching the read data edge by edge, which catches a synchronizer with one stage too few or too many. It hands pins to peripherals and writes new latch values meanwhile, so a design that blocked those writes, or left the override stuck after release, would show stale pin values. It also pulses reset after loading the latches: a design that reset the latch, or failed to clear a direction bit, reads back the wrong value or leaves an output enabled.

// File: rtl/gpio_pkg.sv
package gpio_pkg;

   typedef enum logic [2:0] {
      SEL_NONE,
      SEL_WIDE_DATA,
      SEL_WIDE_DIR,
      SEL_NARROW_DATA,
      SEL_NARROW_DIR
   } reg_sel_e;

   function automatic logic merge_bit(input logic latch_b, input logic dir_b, input logic pin_b);
      return dir_b ? latch_b : pin_b;
   endfunction

endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
   parameter int W      = 8,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] async_in,
   output logic [W-1:0] sync_out
);

   if (STAGES < 2) begin : g_bad_stages
      $error("gpio_sync: STAGES must be at least 2");
   end
   if (W < 1) begin : g_bad_width
      $error("gpio_sync: W must be positive");
   end

   logic [W-1:0] stage_q [STAGES];

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
         always_ff @(posedge clk) begin
            if (!rst_n) stage_q[s] <= '0;
            else        stage_q[s] <= async_in;
         end
      end else begin : g_next
         always_ff @(posedge clk) begin
            if (!rst_n) stage_q[s] <= '0;
            else        stage_q[s] <= stage_q[s-1];
         end
      end
   end

   assign sync_out = stage_q[STAGES-1];

endmodule

// File: rtl/gpio_port_regs.sv
module gpio_port_regs #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         data_we,
   input  logic         dir_we,
   input  logic [W-1:0] wdata,
   output logic [W-1:0] latch_q,
   output logic [W-1:0] dir_q
);

   if (W < 1) begin : g_bad_width
      $error("gpio_port_regs: W must be positive");
   end

   // Output latch: deliberately without reset, its value survives reset.
   always_ff @(posedge clk) begin
      if (data_we) latch_q <= wdata;
   end

   // Direction register: cleared by reset so that every pin starts as input.
   always_ff @(posedge clk) begin
      if (!rst_n)      dir_q <= '0;
      else if (dir_we) dir_q <= wdata;
   end

endmodule

// File: rtl/gpio_pin_mux.sv
module gpio_pin_mux #(
   parameter int W = 8
) (
   input  logic [W-1:0] latch_q,
   input  logic [W-1:0] dir_q,
   input  logic [W-1:0] alt_en,
   input  logic [W-1:0] alt_val,
   input  logic [W-1:0] alt_od,
   output logic [W-1:0] pin_out,
   output logic [W-1:0] pin_oe
);

   for (genvar i = 0; i < W; i++) begin : g_pin
      always_comb begin
         if (alt_en[i]) begin
            if (alt_od[i]) begin
               pin_out[i] = 1'b0;
               pin_oe[i]  = ~alt_val[i];
            end else begin
               pin_out[i] = alt_val[i];
               pin_oe[i]  = 1'b1;
            end
         end else begin
            pin_out[i] = latch_q[i];
            pin_oe[i]  = dir_q[i];
         end
      end
   end

endmodule

// File: rtl/gpio_port_unit.sv
module gpio_port_unit #(
   parameter int          DATA_W           = 8,
   parameter int          ADDR_W           = 8,
   parameter int          WIDE_W           = 8,
   parameter int          NARROW_W         = 2,
   parameter int          PWM_W            = 6,
   parameter int          SER_W            = 2,
   parameter int          SYNC_STAGES      = 2,
   parameter logic [7:0]  WIDE_DATA_ADDR   = 8'h02,
   parameter logic [7:0]  NARROW_DATA_ADDR = 8'h03,
   parameter logic [7:0]  WIDE_DIR_ADDR    = 8'h06,
   parameter logic [7:0]  NARROW_DIR_ADDR  = 8'h07
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [ADDR_W-1:0]   bus_addr,
   input  logic                bus_wr,
   input  logic                bus_rd,
   input  logic [DATA_W-1:0]   bus_wdata,
   output logic [DATA_W-1:0]   bus_rdata,
   input  logic [WIDE_W-1:0]   wide_pin_in,
   output logic [WIDE_W-1:0]   wide_pin_out,
   output logic [WIDE_W-1:0]   wide_pin_oe,
   output logic [WIDE_W-1:0]   wide_pin_sync,
   input  logic [NARROW_W-1:0] narrow_pin_in,
   output logic [NARROW_W-1:0] narrow_pin_out,
   output logic [NARROW_W-1:0] narrow_pin_oe,
   output logic [NARROW_W-1:0] narrow_pin_sync,
   input  logic [PWM_W-1:0]    pwm_sel,
   input  logic [PWM_W-1:0]    pwm_val,
   input  logic [SER_W-1:0]    ser_sel,
   input  logic [SER_W-1:0]    ser_val,
   input  logic [NARROW_W-1:0] sbus_sel,
   input  logic [NARROW_W-1:0] sbus_val
);

   import gpio_pkg::*;

   localparam int SER_BASE = WIDE_W - SER_W;
   localparam logic [ADDR_W-1:0] A_WDATA = ADDR_W'(WIDE_DATA_ADDR);
   localparam logic [ADDR_W-1:0] A_NDATA = ADDR_W'(NARROW_DATA_ADDR);
   localparam logic [ADDR_W-1:0] A_WDIR  = ADDR_W'(WIDE_DIR_ADDR);
   localparam logic [ADDR_W-1:0] A_NDIR  = ADDR_W'(NARROW_DIR_ADDR);

   if (WIDE_W > DATA_W || NARROW_W > DATA_W) begin : g_bad_port_w
      $error("gpio_port_unit: a port is wider than the data bus");
   end
   if (PWM_W + SER_W > WIDE_W) begin : g_bad_alt_w
      $error("gpio_port_unit: PWM and serial pins overlap");
   end
   if (ADDR_W < 3) begin : g_bad_addr_w
      $error("gpio_port_unit: address too narrow for the register map");
   end

   // Address decode
   reg_sel_e sel;
   always_comb begin
      if      (bus_addr == A_WDATA) sel = SEL_WIDE_DATA;
      else if (bus_addr == A_WDIR)  sel = SEL_WIDE_DIR;
      else if (bus_addr == A_NDATA) sel = SEL_NARROW_DATA;
      else if (bus_addr == A_NDIR)  sel = SEL_NARROW_DIR;
      else                          sel = SEL_NONE;
   end

   // Register storage
   logic [WIDE_W-1:0]   w_latch, w_dir;
   logic [NARROW_W-1:0] n_latch, n_dir;

   gpio_port_regs #(.W(WIDE_W)) u_wide_regs (
      .clk     (clk),
      .rst_n   (rst_n),
      .data_we (bus_wr && sel == SEL_WIDE_DATA),
      .dir_we  (bus_wr && sel == SEL_WIDE_DIR),
      .wdata   (bus_wdata[WIDE_W-1:0]),
      .latch_q (w_latch),
      .dir_q   (w_dir)
   );

   gpio_port_regs #(.W(NARROW_W)) u_narrow_regs (
      .clk     (clk),
      .rst_n   (rst_n),
      .data_we (bus_wr && sel == SEL_NARROW_DATA),
      .dir_we  (bus_wr && sel == SEL_NARROW_DIR),
      .wdata   (bus_wdata[NARROW_W-1:0]),
      .latch_q (n_latch),
      .dir_q   (n_dir)
   );

   // Input synchronizers
   gpio_sync #(.W(WIDE_W), .STAGES(SYNC_STAGES)) u_wide_sync (
      .clk      (clk),
      .rst_n    (rst_n),
      .async_in (wide_pin_in),
      .sync_out (wide_pin_sync)
   );

   gpio_sync #(.W(NARROW_W), .STAGES(SYNC_STAGES)) u_narrow_sync (
      .clk      (clk),
      .rst_n    (rst_n),
      .async_in (narrow_pin_in),
      .sync_out (narrow_pin_sync)
   );

   // Alternate function routing onto the wide port
   logic [WIDE_W-1:0] w_alt_en, w_alt_val;
   for (genvar i = 0; i < WIDE_W; i++) begin : g_wide_alt
      if (i < PWM_W) begin : g_pwm
         assign w_alt_en[i]  = pwm_sel[i];
         assign w_alt_val[i] = pwm_val[i];
      end else if (i >= SER_BASE) begin : g_ser
         assign w_alt_en[i]  = ser_sel[i-SER_BASE];
         assign w_alt_val[i] = ser_val[i-SER_BASE];
      end else begin : g_plain
         assign w_alt_en[i]  = 1'b0;
         assign w_alt_val[i] = 1'b0;
      end
   end

   gpio_pin_mux #(.W(WIDE_W)) u_wide_mux (
      .latch_q (w_latch),
      .dir_q   (w_dir),
      .alt_en  (w_alt_en),
      .alt_val (w_alt_val),
      .alt_od  ({WIDE_W{1'b0}}),
      .pin_out (wide_pin_out),
      .pin_oe  (wide_pin_oe)
   );

   gpio_pin_mux #(.W(NARROW_W)) u_narrow_mux (
      .latch_q (n_latch),
      .dir_q   (n_dir),
      .alt_en  (sbus_sel),
      .alt_val (sbus_val),
      .alt_od  ({NARROW_W{1'b1}}),
      .pin_out (narrow_pin_out),
      .pin_oe  (narrow_pin_oe)
   );

   // Read path: direction-dependent merge, zero-extended to the bus
   logic [DATA_W-1:0] w_data_rd, w_dir_rd, n_data_rd, n_dir_rd;
   always_comb begin
      w_data_rd = '0;
      w_dir_rd  = '0;
      n_data_rd = '0;
      n_dir_rd  = '0;
      for (int i = 0; i < WIDE_W; i++) begin
         w_data_rd[i] = merge_bit(w_latch[i], w_dir[i], wide_pin_sync[i]);
         w_dir_rd[i]  = w_dir[i];
      end
      for (int i = 0; i < NARROW_W; i++) begin
         n_data_rd[i] = merge_bit(n_latch[i], n_dir[i], narrow_pin_sync[i]);
         n_dir_rd[i]  = n_dir[i];
      end
   end

   always_comb begin
      bus_rdata = '0;
      if (bus_rd) begin
         unique case (sel)
            SEL_WIDE_DATA:   bus_rdata = w_data_rd;
            SEL_WIDE_DIR:    bus_rdata = w_dir_rd;
            SEL_NARROW_DATA: bus_rdata = n_data_rd;
            SEL_NARROW_DIR:  bus_rdata = n_dir_rd;
            default:         bus_rdata = '0;
         endcase
      end
   end

endmodule

// File: rtl/gpio_port_unit_chk.sv
module gpio_port_unit_chk #(
   parameter int          DATA_W           = 8,
   parameter int          ADDR_W           = 8,
   parameter int          WIDE_W           = 8,
   parameter int          NARROW_W         = 2,
   parameter int          PWM_W            = 6,
   parameter int          SER_W            = 2,
   parameter int          SYNC_STAGES      = 2,
   parameter logic [7:0]  WIDE_DATA_ADDR   = 8'h02,
   parameter logic [7:0]  NARROW_DATA_ADDR = 8'h03,
   parameter logic [7:0]  WIDE_DIR_ADDR    = 8'h06,
   parameter logic [7:0]  NARROW_DIR_ADDR  = 8'h07
) (
   input logic                clk,
   input logic                rst_n,
   input logic [ADDR_W-1:0]   bus_addr,
   input logic                bus_rd,
   input logic [DATA_W-1:0]   bus_rdata,
   input logic [WIDE_W-1:0]   wide_pin_in,
   input logic [WIDE_W-1:0]   wide_pin_out,
   input logic [WIDE_W-1:0]   wide_pin_oe,
   input logic [WIDE_W-1:0]   wide_pin_sync,
   input logic [NARROW_W-1:0] narrow_pin_in,
   input logic [NARROW_W-1:0] narrow_pin_out,
   input logic [NARROW_W-1:0] narrow_pin_oe,
   input logic [NARROW_W-1:0] narrow_pin_sync,
   input logic [PWM_W-1:0]    pwm_sel,
   input logic [PWM_W-1:0]    pwm_val,
   input logic [SER_W-1:0]    ser_sel,
   input logic [SER_W-1:0]    ser_val,
   input logic [NARROW_W-1:0] sbus_sel,
   input logic [NARROW_W-1:0] sbus_val
);

   localparam int SER_BASE = WIDE_W - SER_W;

   logic [WIDE_W-1:0] pwm_mask, pwm_v, ser_mask, ser_v;
   always_comb begin
      pwm_mask = '0; pwm_v = '0; ser_mask = '0; ser_v = '0;
      for (int i = 0; i < PWM_W; i++) begin
         pwm_mask[i] = pwm_sel[i];
         pwm_v[i]    = pwm_val[i];
      end
      for (int j = 0; j < SER_W; j++) begin
         ser_mask[SER_BASE+j] = ser_sel[j];
         ser_v[SER_BASE+j]    = ser_val[j];
      end
   end

   // Cycles since reset release, saturating; gates the synchronizer check.
   logic [1:0] since_rst;
   always_ff @(posedge clk) begin
      if (!rst_n)               since_rst <= '0;
      else if (since_rst != 2'd3) since_rst <= since_rst + 2'd1;
   end

   // R1
   a_r1_dir_cleared: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> ((wide_pin_oe & ~(pwm_mask | ser_mask)) == '0 &&
                        (narrow_pin_oe & ~sbus_sel) == '0));

   // R4
   a_r4_oe_matches_dir: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_rd && bus_addr == ADDR_W'(WIDE_DIR_ADDR) && pwm_sel == '0 && ser_sel == '0)
      |-> (bus_rdata[WIDE_W-1:0] == wide_pin_oe));

   // R6
   a_r6_narrow_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_rd && (bus_addr == ADDR_W'(NARROW_DATA_ADDR) || bus_addr == ADDR_W'(NARROW_DIR_ADDR)))
      |-> ((bus_rdata >> NARROW_W) == '0));

   // R7
   a_r7_two_stage_sync: assert property (@(posedge clk) disable iff (!rst_n)
      (since_rst >= 2'd2) |-> (wide_pin_sync == $past(wide_pin_in, 2) &&
                               narrow_pin_sync == $past(narrow_pin_in, 2)));

   // R8
   a_r8_pwm_override: assert property (@(posedge clk) disable iff (!rst_n)
      (pwm_sel != '0) |-> (((wide_pin_out ^ pwm_v) & pwm_mask) == '0 &&
                           (wide_pin_oe & pwm_mask) == pwm_mask));

   // R9
   a_r9_serial_override: assert property (@(posedge clk) disable iff (!rst_n)
      (ser_sel != '0) |-> (((wide_pin_out ^ ser_v) & ser_mask) == '0 &&
                           (wide_pin_oe & ser_mask) == ser_mask));

   // R10
   a_r10_open_drain: assert property (@(posedge clk) disable iff (!rst_n)
      (sbus_sel != '0) |-> ((narrow_pin_out & sbus_sel) == '0 &&
                            ((narrow_pin_oe ^ ~sbus_val) & sbus_sel) == '0));

   // R12
   a_r12_idle_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_rd |-> (bus_rdata == '0));

endmodule

bind gpio_port_unit gpio_port_unit_chk #(
   .DATA_W(DATA_W), .ADDR_W(ADDR_W), .WIDE_W(WIDE_W), .NARROW_W(NARROW_W),
   .PWM_W(PWM_W), .SER_W(SER_W), .SYNC_STAGES(SYNC_STAGES),
   .WIDE_DATA_ADDR(WIDE_DATA_ADDR), .NARROW_DATA_ADDR(NARROW_DATA_ADDR),
   .WIDE_DIR_ADDR(WIDE_DIR_ADDR), .NARROW_DIR_ADDR(NARROW_DIR_ADDR)
) u_chk (.*);

// File: tb/gpio_port_unit_tb.sv
module gpio_port_unit_tb;

   localparam int CLK_P = 10;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [7:0] bus_addr = '0;
   logic       bus_wr = 1'b0, bus_rd = 1'b0;
   logic [7:0] bus_wdata = '0, bus_rdata;
   logic [7:0] wide_pin_in = '0, wide_pin_out, wide_pin_oe, wide_pin_sync;
   logic [1:0] narrow_pin_in = '0, narrow_pin_out, narrow_pin_oe, narrow_pin_sync;
   logic [5:0] pwm_sel = '0, pwm_val = '0;
   logic [1:0] ser_sel = '0, ser_val = '0, sbus_sel = '0, sbus_val = '0;

   int n_checks = 0, n_fail = 0;
   bit cmp_en = 1'b0;

   always #(CLK_P/2) clk = ~clk;

   gpio_port_unit u_dut (.*);

   // ---------------- behavioural reference model ----------------
   logic [7:0] m_wlat, m_wdir, m_wknown, m_ws1, m_ws2;
   logic [1:0] m_nlat, m_ndir, m_nknown, m_ns1, m_ns2;
   initial begin
      m_wlat = '0; m_wdir = '0; m_wknown = '0; m_ws1 = '0; m_ws2 = '0;
      m_nlat = '0; m_ndir = '0; m_nknown = '0; m_ns1 = '0; m_ns2 = '0;
   end

   always @(posedge clk) begin
      if (bus_wr && bus_addr == 8'h02) begin m_wlat = bus_wdata; m_wknown = 8'hFF; end
      if (bus_wr && bus_addr == 8'h03) begin m_nlat = bus_wdata[1:0]; m_nknown = 2'b11; end
      if (!rst_n) begin
         m_wdir = '0; m_ndir = '0;
         m_ws1 = '0; m_ws2 = '0; m_ns1 = '0; m_ns2 = '0;
      end else begin
         if (bus_wr && bus_addr == 8'h06) m_wdir = bus_wdata;
         if (bus_wr && bus_addr == 8'h07) m_ndir = bus_wdata[1:0];
         m_ws2 = m_ws1; m_ws1 = wide_pin_in;
         m_ns2 = m_ns1; m_ns1 = narrow_pin_in;
      end
   end

   task automatic chk(input bit ok, input string tag, input logic [7:0] act, input logic [7:0] exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %02h expected %02h at %0t", tag, act, exp, $time);
      end
   endtask

   // Per-clock comparison against the model, sampled away from the edge
   always begin
      @(negedge clk);
      #(CLK_P/4);
      if (cmp_en) begin
         logic [7:0] e_woe, e_wout, w_care, e_rd, rd_care;
         logic [1:0] e_noe, e_nout, n_care;
         for (int i = 0; i < 8; i++) begin
            if (i < 6 && pwm_sel[i]) begin
               e_woe[i] = 1'b1; e_wout[i] = pwm_val[i]; w_care[i] = 1'b1;
            end else if (i >= 6 && ser_sel[i-6]) begin
               e_woe[i] = 1'b1; e_wout[i] = ser_val[i-6]; w_care[i] = 1'b1;
            end else begin
               e_woe[i] = m_wdir[i]; e_wout[i] = m_wlat[i]; w_care[i] = m_wdir[i] & m_wknown[i];
            end
         end
         for (int k = 0; k < 2; k++) begin
            if (sbus_sel[k]) begin
               e_noe[k] = ~sbus_val[k]; e_nout[k] = 1'b0; n_care[k] = 1'b1;
            end else begin
               e_noe[k] = m_ndir[k]; e_nout[k] = m_nlat[k]; n_care[k] = m_ndir[k] & m_nknown[k];
            end
         end
         e_rd = '0; rd_care = 8'hFF;
         if (bus_rd) begin
            case (bus_addr)
               8'h02: begin e_rd = (m_wlat & m_wdir) | (m_ws2 & ~m_wdir);
                            rd_care = ~m_wdir | m_wknown; end
               8'h06: e_rd = m_wdir;
               8'h03: begin e_rd = {6'b0, (m_nlat & m_ndir) | (m_ns2 & ~m_ndir)};
                            rd_care = {6'h3F, ~m_ndir | m_nknown}; end
               8'h07: e_rd = {6'b0, m_ndir};
               default: e_rd = '0;
            endcase
         end
         chk(wide_pin_oe == e_woe, "R4/R8/R9 wide oe", wide_pin_oe, e_woe);
         chk(((wide_pin_out ^ e_wout) & w_care) == '0, "R4/R8/R9 wide out", wide_pin_out, e_wout);
         chk(narrow_pin_oe == e_noe, "R4/R10 narrow oe", {6'b0, narrow_pin_oe}, {6'b0, e_noe});
         chk(((narrow_pin_out ^ e_nout) & n_care) == '0, "R4/R10 narrow out",
             {6'b0, narrow_pin_out}, {6'b0, e_nout});
         chk(((bus_rdata ^ e_rd) & rd_care) == '0, "R6/R12 read data", bus_rdata, e_rd);
         chk(wide_pin_sync == m_ws2 && narrow_pin_sync == m_ns2, "R7 sync outputs",
             wide_pin_sync, m_ws2);
      end
   end

   // ---------------- stimulus helpers ----------------
   task automatic wr(input logic [7:0] a, input logic [7:0] d);
      @(negedge clk);
      bus_addr = a; bus_wdata = d; bus_wr = 1'b1; bus_rd = 1'b0;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic rd_chk(input logic [7:0] a, input logic [7:0] exp, input string tag);
      @(negedge clk);
      bus_addr = a; bus_rd = 1'b1; bus_wr = 1'b0;
      #(CLK_P/4);
      chk(bus_rdata == exp, tag, bus_rdata, exp);
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic run_all();
      // Reset state
      idle(3);
      cmp_en = 1'b1;
      @(negedge clk); rst_n = 1'b1;
      rd_chk(8'h06, 8'h00, "R1 wide dir after reset");
      rd_chk(8'h07, 8'h00, "R1 narrow dir after reset");
      chk(wide_pin_oe == 8'h00, "R1 wide oe after reset", wide_pin_oe, 8'h00);

      // Latch write while input; merged read
      @(negedge clk); wide_pin_in = 8'h3C;
      wr(8'h02, 8'hA5);
      idle(2);
      rd_chk(8'h02, 8'h3C, "R5 input read while latch written");
      wr(8'h06, 8'hF0);
      rd_chk(8'h02, 8'hAC, "R6 merged read");
      chk(wide_pin_oe == 8'hF0, "R4 oe follows dir", wide_pin_oe, 8'hF0);
      chk((wide_pin_out & 8'hF0) == 8'hA0, "R4 latch on output pins", wide_pin_out & 8'hF0, 8'hA0);

      // Synchronizer latency
      wr(8'h06, 8'h00);
      rd_chk(8'h02, 8'h3C, "R7 before change");
      wide_pin_in = 8'h81;
      #(CLK_P/4);
      chk(bus_rdata == 8'h3C, "R7 no change at once", bus_rdata, 8'h3C);
      @(negedge clk); #(CLK_P/4);
      chk(bus_rdata == 8'h3C, "R7 one edge later", bus_rdata, 8'h3C);
      @(negedge clk); #(CLK_P/4);
      chk(bus_rdata == 8'h81, "R7 two edges later", bus_rdata, 8'h81);

      // Unmapped addresses
      wr(8'h04, 8'hFF); wr(8'h00, 8'hFF); wr(8'h05, 8'hFF); wr(8'h42, 8'hFF);
      rd_chk(8'h06, 8'h00, "R3 stray write leaves dir");
      rd_chk(8'h04, 8'h00, "R3 unmapped read");
      wr(8'h06, 8'hFF);
      rd_chk(8'h02, 8'hA5, "R3 stray write leaves latch");

      // Narrow port read width
      wr(8'h03, 8'hFF); wr(8'h07, 8'hFF);
      rd_chk(8'h03, 8'h03, "R6 narrow data upper bits zero");
      rd_chk(8'h07, 8'h03, "R6 narrow dir upper bits zero");

      // PWM ownership
      @(negedge clk); pwm_sel = 6'h3F; pwm_val = 6'h15;
      #(CLK_P/4);
      chk(wide_pin_out == 8'h95, "R8 pwm drives low pins", wide_pin_out, 8'h95);
      wr(8'h02, 8'h0F);
      @(negedge clk); pwm_sel = '0;
      #(CLK_P/4);
      chk(wide_pin_out == 8'h0F, "R11 latch written while owned", wide_pin_out, 8'h0F);

      // Serial ownership of top pins
      wr(8'h06, 8'h00);
      @(negedge clk); ser_sel = 2'b10; ser_val = 2'b00;
      #(CLK_P/4);
      chk(wide_pin_oe == 8'h80, "R9 serial owns pin 7 only", wide_pin_oe, 8'h80);
      chk(wide_pin_out[7] == 1'b0, "R9 serial value 0", {7'b0, wide_pin_out[7]}, 8'h00);
      @(negedge clk); ser_val = 2'b10;
      #(CLK_P/4);
      chk(wide_pin_out[7] == 1'b1, "R9 serial value 1", {7'b0, wide_pin_out[7]}, 8'h01);
      @(negedge clk); ser_sel = 2'b01; ser_val = 2'b01;
      #(CLK_P/4);
      chk(wide_pin_oe == 8'h40 && wide_pin_out[6], "R9 serial bit0 on pin 6", wide_pin_oe, 8'h40);
      @(negedge clk); ser_sel = '0;

      // Open-drain bus
      @(negedge clk); sbus_sel = 2'b11; sbus_val = 2'b01;
      #(CLK_P/4);
      chk(narrow_pin_oe == 2'b10, "R10 open drain enable", {6'b0, narrow_pin_oe}, 8'h02);
      chk(narrow_pin_out == 2'b00, "R10 open drain drives low", {6'b0, narrow_pin_out}, 8'h00);
      wr(8'h07, 8'h01);
      @(negedge clk); sbus_sel = '0;
      #(CLK_P/4);
      chk(narrow_pin_oe == 2'b01, "R11 dir written while owned", {6'b0, narrow_pin_oe}, 8'h01);

      // Reset retains latches
      wr(8'h02, 8'h5A); wr(8'h06, 8'hFF);
      @(negedge clk); rst_n = 1'b0;
      idle(2);
      @(negedge clk); rst_n = 1'b1;
      #(CLK_P/4);
      chk(wide_pin_oe == 8'h00, "R1 mid-run reset clears dir", wide_pin_oe, 8'h00);
      rd_chk(8'h06, 8'h00, "R1 dir reads zero");
      wr(8'h06, 8'hFF);
      rd_chk(8'h02, 8'h5A, "R2 latch survives reset");

      // Idle read strobe
      @(negedge clk); bus_rd = 1'b0; bus_addr = 8'h02;
      #(CLK_P/4);
      chk(bus_rdata == 8'h00, "R12 read strobe low", bus_rdata, 8'h00);

      // Mixed traffic checked by the model each clock
      for (int c = 0; c < 400; c++) begin
         @(negedge clk);
         wide_pin_in   = 8'($urandom);
         narrow_pin_in = 2'($urandom);
         bus_rd        = ($urandom % 4) != 0;
         bus_wr        = ($urandom % 3) == 0;
         bus_wdata     = 8'($urandom);
         case ($urandom % 5)
            0: bus_addr = 8'h02;
            1: bus_addr = 8'h03;
            2: bus_addr = 8'h06;
            3: bus_addr = 8'h07;
            default: bus_addr = 8'($urandom);
         endcase
         if ($urandom % 8 == 0) begin
            pwm_sel = 6'($urandom); ser_sel = 2'($urandom); sbus_sel = 2'($urandom);
         end
         pwm_val = 6'($urandom); ser_val = 2'($urandom); sbus_val = 2'($urandom);
      end
      @(negedge clk); bus_wr = 1'b0;
      idle(2);
   endtask

   initial begin
      fork
         run_all();
         begin
            repeat (50000) @(posedge clk);
            n_checks++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
         end
      join_any
      disable fork;
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
   end

endmodule